// File: doc/BRIEF.md
# Torus Mesh Packet Router

This block is one node of a nine-node on-chip network laid out as a 3×3 torus. Each dimension is a ring of three nodes, and the wraparound links close the ring. The router has five flit ports. Four of them face the neighbouring nodes: east and west along X, north and south along Y. The fifth, the local port, serves the processing element attached to this node. Every port moves flits with a valid/ready handshake in each direction.

Traffic is carried as short packets (fragments), so no single stream holds a link for long. The first flit of a packet is its header. The header gives the destination node's coordinates, plus a function tag and a stream tag that the receiving element uses to pick its parameters and its per-stream context. The router forwards these tags untouched. It routes minimally in dimension order: the X ring is settled completely before any Y hop is taken, and on each ring it takes the shorter way round. Forwarding is wormhole. A header that wins an output keeps that output for its input until the tail flit has passed. Each output chooses among competing headers in round-robin order, so fragments of different streams take turns on a link.

The node's own coordinates are set by parameters. Each input has a small flit buffer, so a flit accepted on one clock edge can appear at an output right after that edge.

Top module: `torus_router`

## Requirements
- R1: A header whose X offset (destination X minus node X, modulo 3) is 1 leaves on the east output (port 1). An X offset of 2 leaves on the west output (port 2). The Y offset does not matter while the X offset is non-zero.
- R2: A header whose X offset is 0 and whose Y offset is 1 leaves on the north output (port 3). A Y offset of 2 leaves on the south output (port 4).
- R3: A header whose X and Y offsets are both 0 leaves on the local output (port 0).
- R4: After a header that is not also a tail passes an output, the flits that follow on that output come only from the same input, in order, until that packet's tail flit has passed.
- R5: While an output is free, it grants the first requesting input found when scanning upward (with wrap) from the input after the one whose packet last completed on that output. After reset the scan starts at input 0.
- R6: Each input holds at most 2 flits. Its ready is low exactly while 2 flits are held. No accepted flit is lost or duplicated.
- R7: On an idle router, a flit accepted at a clock edge is offered on its output directly after that edge.
- R8: Every flit, header fields included, leaves bit-for-bit as it arrived. The flit layout is: bit 17 header, bit 16 tail, bits 15:0 payload. In a header, bits 1:0 hold the destination X, bits 3:2 the destination Y, bits 7:4 the function tag and bits 11:8 the stream tag.
- R9: After synchronous reset all out_valid bits are low and all in_ready bits are high.
- R10: While an output is valid and not ready, it stays valid with the same flit on the next cycle.

Port index order is local 0, east 1, west 2, north 3, south 4. The same order applies to inputs and outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 5 | Flit present on each input port |
| in_flit | input | 5×18 | Flit on each input port |
| in_ready | output | 5 | Each input port can take a flit |
| out_valid | output | 5 | Flit offered on each output port |
| out_flit | output | 5×18 | Flit on each output port |
| out_ready | input | 5 | Downstream takes the offered flit |

## Verification
Every result is due a fixed number of cycles after its stimulus. A flit taken at one rising edge is held in an input buffer and can appear on its output right after that same edge. A change in buffer occupancy shows on in_ready after the edge that caused it. Arbitration and lock state change on the edge where a flit is offered or taken, and their effect shows on the outputs after that edge. The bench drives inputs and samples every output at the falling edge, half a cycle after each rising edge. On each cycle it compares the outputs with a behavioural model that has been advanced by exactly one edge. Directed sequences then check the route of each destination, the first-cycle latency, the grant order and wormhole integrity against values worked out from the requirements.

// File: rtl/torus_pkg.sv
package torus_pkg;

    localparam int RADIX   = 3;
    localparam int COORD_W = $clog2(RADIX);
    localparam int DATA_W  = 16;
    localparam int NPORT   = 5;
    localparam int PORT_W  = $clog2(NPORT);
    localparam int FLIT_W  = DATA_W + 2;

    // header field positions inside the payload
    localparam int DX_LSB  = 0;
    localparam int DY_LSB  = COORD_W;

    localparam logic [COORD_W:0]   RING_N    = (COORD_W+1)'(RADIX);
    localparam logic [COORD_W-1:0] RING_HALF = COORD_W'(RADIX / 2);

    typedef enum logic [PORT_W-1:0] {
        P_LOCAL = 3'd0,
        P_EAST  = 3'd1,
        P_WEST  = 3'd2,
        P_NORTH = 3'd3,
        P_SOUTH = 3'd4
    } port_e;

    typedef struct packed {
        logic              head;
        logic              tail;
        logic [DATA_W-1:0] data;
    } flit_t;

    // distance from here to dst going the positive way round a ring
    function automatic logic [COORD_W-1:0] ring_off(input logic [COORD_W-1:0] dst,
                                                    input logic [COORD_W-1:0] here);
        logic [COORD_W:0] s;
        s = {1'b0, dst} + RING_N - {1'b0, here};
        if (s >= RING_N) s = s - RING_N;
        return s[COORD_W-1:0];
    endfunction

    // X first, then Y; on each ring take the shorter way
    function automatic port_e route_pick(input logic [COORD_W-1:0] dx,
                                         input logic [COORD_W-1:0] dy,
                                         input logic [COORD_W-1:0] hx,
                                         input logic [COORD_W-1:0] hy);
        logic [COORD_W-1:0] ox, oy;
        ox = ring_off(dx, hx);
        oy = ring_off(dy, hy);
        if (ox != '0)      return (ox <= RING_HALF) ? P_EAST  : P_WEST;
        else if (oy != '0) return (oy <= RING_HALF) ? P_NORTH : P_SOUTH;
        else               return P_LOCAL;
    endfunction

endpackage

// File: rtl/torus_in_fifo.sv
module torus_in_fifo import torus_pkg::*; #(
    parameter int DEPTH = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  push_valid,
    input  flit_t push_flit,
    output logic  push_ready,
    output logic  head_valid,
    output flit_t head_flit,
    input  logic  pop
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    flit_t            mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push, do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign push_ready = (count != CNT_W'(DEPTH));
    assign head_valid = (count != '0);
    assign head_flit  = mem[rd_ptr];
    assign do_push    = push_valid && push_ready;
    assign do_pop     = pop && head_valid;

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_flit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (push_valid && push_ready && !pop && count == CNT_W'(DEPTH - 1)) |=> !push_ready);

    // R6
    pop_empty_chk: assert property (@(posedge clk) disable iff (rst)
        pop |-> head_valid);

endmodule

// File: rtl/torus_in_route.sv
module torus_in_route import torus_pkg::*; #(
    parameter int MY_X = 0,
    parameter int MY_Y = 0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               head_valid,
    input  logic               is_head,
    input  logic [COORD_W-1:0] dst_x,
    input  logic [COORD_W-1:0] dst_y,
    input  logic               pop,
    output logic [NPORT-1:0]   req
);

    localparam logic [COORD_W-1:0] HX = COORD_W'(MY_X);
    localparam logic [COORD_W-1:0] HY = COORD_W'(MY_Y);

    port_e calc, held, dir;

    assign calc = route_pick(dst_x, dst_y, HX, HY);
    assign dir  = is_head ? calc : held;

    always_comb begin
        req = '0;
        if (head_valid) req[dir] = 1'b1;
    end

    // body flits follow the direction their header took
    always_ff @(posedge clk) begin
        if (rst)                            held <= P_LOCAL;
        else if (pop && head_valid && is_head) held <= calc;
    end

endmodule

// File: rtl/torus_out_arb.sv
module torus_out_arb import torus_pkg::*; (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPORT-1:0] req,
    input  flit_t            cand_flit [NPORT],
    input  logic             out_ready,
    output logic [NPORT-1:0] grant,
    output logic             out_valid,
    output flit_t            out_flit
);

    logic              locked;
    logic [PORT_W-1:0] owner, rr_ptr, pick, sel;
    logic              pick_ok, sel_ok, fire;

    function automatic logic [PORT_W-1:0] wrap_add(input logic [PORT_W-1:0] p, input int k);
        int t;
        t = int'(p) + k;
        if (t >= NPORT) t = t - NPORT;
        return PORT_W'(t);
    endfunction

    always_comb begin
        pick    = rr_ptr;
        pick_ok = 1'b0;
        for (int k = 0; k < NPORT; k++) begin
            if (!pick_ok && req[wrap_add(rr_ptr, k)]) begin
                pick    = wrap_add(rr_ptr, k);
                pick_ok = 1'b1;
            end
        end
    end

    assign sel       = locked ? owner : pick;
    assign sel_ok    = locked ? req[owner] : pick_ok;
    assign out_valid = sel_ok;
    assign out_flit  = cand_flit[sel];
    assign grant     = sel_ok ? (NPORT'(1) << sel) : '0;
    assign fire      = sel_ok && out_ready;

    // the lock is taken at grant time so the offer cannot change under backpressure
    always_ff @(posedge clk) begin
        if (rst) begin
            locked <= 1'b0;
            owner  <= '0;
            rr_ptr <= '0;
        end else if (fire && out_flit.tail) begin
            locked <= 1'b0;
            rr_ptr <= wrap_add(sel, 1);
        end else if (sel_ok) begin
            locked <= 1'b1;
            owner  <= sel;
        end
    end

    // R10
    hold_offer_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_flit)));

    // R4
    worm_owner_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && !out_flit.tail) |=> (!out_valid || grant == $past(grant)));

    // R5
    grant_legal_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant) && ((grant & ~req) == '0));

endmodule

// File: rtl/torus_router.sv
module torus_router import torus_pkg::*; #(
    parameter int MY_X      = 0,
    parameter int MY_Y      = 0,
    parameter int BUF_DEPTH = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NPORT-1:0]             in_valid,
    input  logic [NPORT-1:0][FLIT_W-1:0] in_flit,
    output logic [NPORT-1:0]             in_ready,
    output logic [NPORT-1:0]             out_valid,
    output logic [NPORT-1:0][FLIT_W-1:0] out_flit,
    input  logic [NPORT-1:0]             out_ready
);

    localparam logic [COORD_W-1:0] HX = COORD_W'(MY_X);
    localparam logic [COORD_W-1:0] HY = COORD_W'(MY_Y);

    flit_t            hd_flit  [NPORT];
    flit_t            o_flit   [NPORT];
    logic [NPORT-1:0] hd_valid, pop;
    logic [NPORT-1:0] req_by_in  [NPORT];
    logic [NPORT-1:0] req_at_out [NPORT];
    logic [NPORT-1:0] grant_out  [NPORT];

    for (genvar i = 0; i < NPORT; i++) begin : g_in
        torus_in_fifo #(.DEPTH(BUF_DEPTH)) u_buf (
            .clk        (clk),
            .rst        (rst),
            .push_valid (in_valid[i]),
            .push_flit  (flit_t'(in_flit[i])),
            .push_ready (in_ready[i]),
            .head_valid (hd_valid[i]),
            .head_flit  (hd_flit[i]),
            .pop        (pop[i])
        );

        torus_in_route #(.MY_X(MY_X), .MY_Y(MY_Y)) u_route (
            .clk        (clk),
            .rst        (rst),
            .head_valid (hd_valid[i]),
            .is_head    (hd_flit[i].head),
            .dst_x      (hd_flit[i].data[DX_LSB +: COORD_W]),
            .dst_y      (hd_flit[i].data[DY_LSB +: COORD_W]),
            .pop        (pop[i]),
            .req        (req_by_in[i])
        );
    end

    always_comb begin
        for (int o = 0; o < NPORT; o++)
            for (int i = 0; i < NPORT; i++)
                req_at_out[o][i] = req_by_in[i][o];
    end

    always_comb begin
        pop = '0;
        for (int o = 0; o < NPORT; o++)
            pop = pop | (grant_out[o] & {NPORT{out_ready[o]}});
    end

    for (genvar o = 0; o < NPORT; o++) begin : g_out
        torus_out_arb u_arb (
            .clk       (clk),
            .rst       (rst),
            .req       (req_at_out[o]),
            .cand_flit (hd_flit),
            .out_ready (out_ready[o]),
            .grant     (grant_out[o]),
            .out_valid (out_valid[o]),
            .out_flit  (o_flit[o])
        );
        assign out_flit[o] = o_flit[o];
    end

    // R3
    local_dest_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid[P_LOCAL] && out_flit[P_LOCAL][FLIT_W-1]) |->
        (out_flit[P_LOCAL][DX_LSB +: COORD_W] == HX && out_flit[P_LOCAL][DY_LSB +: COORD_W] == HY));

endmodule

// File: tb/torus_router_test.sv
module torus_router_test;
    import torus_pkg::*;

    localparam int MX = 0;
    localparam int MY = 2;
    localparam int DEPTH = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NPORT-1:0]             in_valid;
    logic [NPORT-1:0][FLIT_W-1:0] in_flit;
    logic [NPORT-1:0]             in_ready;
    logic [NPORT-1:0]             out_valid;
    logic [NPORT-1:0][FLIT_W-1:0] out_flit;
    logic [NPORT-1:0]             out_ready;

    always #2 clk = ~clk;

    torus_router #(.MY_X(MX), .MY_Y(MY), .BUF_DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_flit(in_flit), .in_ready(in_ready),
        .out_valid(out_valid), .out_flit(out_flit), .out_ready(out_ready)
    );

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    // behavioural model state
    logic [FLIT_W-1:0] sq [NPORT][$];   // flits still to be offered per input
    logic [FLIT_W-1:0] mq [NPORT][$];   // flits held in the router per input
    int held [NPORT];
    bit locked [NPORT];
    int owner [NPORT];
    int rr [NPORT];
    bit prev_hold [NPORT];
    logic [FLIT_W-1:0] prev_flit [NPORT];
    logic [FLIT_W-1:0] loc_log[$];
    logic [FLIT_W-1:0] west_log[$];
    int last_port;
    int seq_no = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s cycle %0d actual %h expected %h", tag, cycles, act, exp);
        end
    endtask

    function automatic int route_of(input logic [FLIT_W-1:0] f);
        int dx, dy;
        dx = (int'(f[1:0]) - MX + 3) % 3;
        dy = (int'(f[3:2]) - MY + 3) % 3;
        if (dx == 1) return 1;
        if (dx == 2) return 2;
        if (dy == 1) return 3;
        if (dy == 2) return 4;
        return 0;
    endfunction

    function automatic string tag_of(input logic [FLIT_W-1:0] f);
        int d;
        if (!f[FLIT_W-1]) return "R4";
        d = route_of(f);
        if (d == 1 || d == 2) return "R1";
        if (d == 3 || d == 4) return "R2";
        return "R3";
    endfunction

    task automatic add_pkt(input int src, input int dx, input int dy, input int len,
                           input int fid, input int sid);
        logic [FLIT_W-1:0] f;
        for (int k = 0; k < len; k++) begin
            f = '0;
            f[FLIT_W-1] = (k == 0);
            f[FLIT_W-2] = (k == len - 1);
            f[15:12] = 4'(src);
            if (k == 0) begin
                f[1:0] = 2'(dx); f[3:2] = 2'(dy); f[7:4] = 4'(fid); f[11:8] = 4'(sid);
            end else begin
                f[11:0] = 12'(seq_no);
                seq_no++;
            end
            sq[src].push_back(f);
        end
    endtask

    // one cycle: called at a falling edge, returns at the next one
    task automatic step(input logic [NPORT-1:0] rdy, input bit rnd_send);
        int dir [NPORT];
        bit hv [NPORT];
        int sel [NPORT];
        bit ev [NPORT];
        bit acc [NPORT];
        logic [FLIT_W-1:0] ef;
        for (int i = 0; i < NPORT; i++) begin
            hv[i] = mq[i].size() > 0;
            dir[i] = -1;
            if (hv[i]) dir[i] = mq[i][0][FLIT_W-1] ? route_of(mq[i][0]) : held[i];
        end
        for (int o = 0; o < NPORT; o++) begin
            ev[o] = 1'b0; sel[o] = 0;
            if (locked[o]) begin
                sel[o] = owner[o];
                ev[o] = hv[owner[o]] && dir[owner[o]] == o;
            end else begin
                for (int k = 0; k < NPORT; k++) begin
                    if (!ev[o] && hv[(rr[o] + k) % NPORT] && dir[(rr[o] + k) % NPORT] == o) begin
                        sel[o] = (rr[o] + k) % NPORT;
                        ev[o] = 1'b1;
                    end
                end
            end
        end
        // compare the design with the model
        for (int i = 0; i < NPORT; i++)
            chk(in_ready[i] == (mq[i].size() < DEPTH), "R6", 32'(in_ready[i]), 32'(mq[i].size() < DEPTH));
        for (int o = 0; o < NPORT; o++) begin
            ef = ev[o] ? mq[sel[o]][0] : '0;
            chk(out_valid[o] == ev[o], tag_of(ev[o] ? ef : out_flit[o]), 32'(out_valid[o]), 32'(ev[o]));
            if (ev[o] && out_valid[o])
                chk(out_flit[o] == ef, tag_of(ef), 32'(out_flit[o]), 32'(ef));
            if (prev_hold[o])
                chk(out_valid[o] && out_flit[o] == prev_flit[o], "R10", 32'(out_flit[o]), 32'(prev_flit[o]));
        end
        // drive this cycle's inputs
        for (int i = 0; i < NPORT; i++) begin
            in_valid[i] = sq[i].size() > 0 && (!rnd_send || $urandom_range(0, 3) != 0);
            in_flit[i]  = sq[i].size() > 0 ? sq[i][0] : '0;
            acc[i] = in_valid[i] && mq[i].size() < DEPTH;
        end
        out_ready = rdy;
        for (int o = 0; o < NPORT; o++) begin
            if (out_valid[o] && out_ready[o]) begin
                last_port = o;
                if (o == 0) loc_log.push_back(out_flit[o]);
                if (o == 2) west_log.push_back(out_flit[o]);
            end
            prev_hold[o] = out_valid[o] && !out_ready[o];
            prev_flit[o] = out_flit[o];
        end
        // advance the model by one edge
        for (int o = 0; o < NPORT; o++) begin
            if (ev[o]) begin
                ef = mq[sel[o]][0];
                if (rdy[o]) begin
                    if (ef[FLIT_W-1]) held[sel[o]] = route_of(ef);
                    void'(mq[sel[o]].pop_front());
                end
                if (rdy[o] && ef[FLIT_W-2]) begin
                    locked[o] = 1'b0;
                    rr[o] = (sel[o] + 1) % NPORT;
                end else begin
                    locked[o] = 1'b1;
                    owner[o] = sel[o];
                end
            end
        end
        for (int i = 0; i < NPORT; i++)
            if (acc[i]) mq[i].push_back(sq[i].pop_front());
        @(negedge clk);
        cycles++;
    endtask

    function automatic bit busy();
        for (int i = 0; i < NPORT; i++)
            if (sq[i].size() > 0 || mq[i].size() > 0 || locked[i]) return 1'b1;
        return 1'b0;
    endfunction

    task automatic run_idle(input int limit, input bit rnd);
        int n = 0;
        while (busy() && n < limit) begin
            step(rnd ? NPORT'($urandom) : '1, rnd);
            n++;
        end
        if (n >= limit) chk(1'b0, "R6 watchdog", 32'(n), 32'(limit));
    endtask

    initial begin
        logic [FLIT_W-1:0] f;
        int exp_src [5] = '{3, 4, 0, 1, 2};
        for (int i = 0; i < NPORT; i++) begin
            held[i] = 0; locked[i] = 0; owner[i] = 0; rr[i] = 0; prev_hold[i] = 0; prev_flit[i] = '0;
        end
        in_valid = '0; in_flit = '0; out_ready = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9: reset state
        chk(out_valid == '0, "R9", 32'(out_valid), 32'(0));
        chk(in_ready == '1, "R9", 32'(in_ready), 32'(5'h1f));

        // R7: one flit to the east neighbour, visible right after the accepting edge
        add_pkt(0, MX + 1, MY, 1, 2, 3);
        f = sq[0][0];
        step('1, 1'b0);
        chk(out_valid[1] == 1'b1 && out_flit[1] == f, "R7", 32'(out_flit[1]), 32'(f));
        run_idle(50, 1'b0);

        // R1 R2 R3: every destination from the local input
        for (int x = 0; x < 3; x++) begin
            for (int y = 0; y < 3; y++) begin
                add_pkt(0, x, y, 1, x, y);
                f = sq[0][0];
                last_port = -1;
                run_idle(50, 1'b0);
                chk(last_port == route_of(f), tag_of(f), 32'(last_port), 32'(route_of(f)));
            end
        end

        // R5 R8: one packet from input 2 moves the local pointer, then all five contend
        add_pkt(2, MX, MY, 1, 1, 1);
        run_idle(50, 1'b0);
        loc_log.delete();
        for (int s = 0; s < NPORT; s++) add_pkt(s, MX, MY, 1, s + 1, s + 8);
        step('0, 1'b0);
        step('0, 1'b0);
        run_idle(100, 1'b0);
        chk(loc_log.size() == 5, "R5", 32'(loc_log.size()), 32'(5));
        for (int k = 0; k < 5 && k < loc_log.size(); k++) begin
            chk(loc_log[k][15:12] == 4'(exp_src[k]), "R5", 32'(loc_log[k][15:12]), 32'(exp_src[k]));
            chk(loc_log[k][7:4] == 4'(exp_src[k] + 1) && loc_log[k][11:8] == 4'(exp_src[k] + 8),
                "R8", 32'(loc_log[k][11:4]), 32'({4'(exp_src[k] + 8), 4'(exp_src[k] + 1)}));
        end

        // R4: two four-flit packets race for the west output under random backpressure
        west_log.delete();
        add_pkt(1, MX + 2, MY, 4, 5, 6);
        add_pkt(3, MX + 2, 0, 4, 7, 9);
        run_idle(500, 1'b1);
        chk(west_log.size() == 8, "R4", 32'(west_log.size()), 32'(8));
        for (int k = 0; k < west_log.size(); k++)
            chk(west_log[k][15:12] == west_log[(k / 4) * 4][15:12], "R4",
                32'(west_log[k][15:12]), 32'(west_log[(k / 4) * 4][15:12]));

        // mixed random traffic, compared with the model every cycle
        for (int p = 0; p < 200; p++)
            add_pkt($urandom_range(0, 4), $urandom_range(0, 2), $urandom_range(0, 2),
                    $urandom_range(1, 4), $urandom_range(0, 15), $urandom_range(0, 15));
        run_idle(20000, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule